// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block recovers characters from an asynchronous serial line that idles high. A one-cycle enable pulse at sixteen times the bit rate paces it. On a falling edge it checks that the line is still low in the middle of the start bit. It then samples each data bit, and the parity bit when one is configured, once at its centre. The first stop bit is checked last. The assembled character is placed right-aligned, with zeros above it, into a one-character holding buffer.

The host reads the buffer through a read strobe and reads the error flags through a status strobe. A request flag tells it that a character is waiting. The configuration inputs select the character length and the parity mode. They are expected to stay constant while a character is being received. The serial line is assumed to be synchronous to `clk` already. The enable pulse comes from an external divider.

Top module: `serial_rx_16x`

## Requirements
- R1: After reset the buffer is empty, the request flag is low and the break, framing, parity and overrun flags are low.
- R2: A low level seen on a tick starts a candidate character. It is accepted only if the line is still low on the eighth tick after that one. A pulse shorter than that produces no character.
- R3: Data bits are sampled every 16 ticks after the validated start point. The first bit after the start bit lands in bit 0 of `rx_byte`.
- R4: `cfg_len` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `rx_byte` above the length read as zero.
- R5: `cfg_par` bit 0 set means a parity bit follows the data. The codes are: 001 odd, 011 even, 101 parity bit must be 1, 111 parity bit must be 0. Codes with bit 0 clear mean no parity. A mismatch sets `perr`.
- R6: If the first stop bit samples low, `ferr` is set.
- R7: If the data bits, the parity bit (when present) and the stop bit all sample low, `brk` is set together with `ferr`.
- R8: A stored character sets `rx_full` and `rx_req`. A `rd_data` pulse clears both. A `req_ack` pulse clears only `rx_req`.
- R9: If a character completes while `rx_full` is high and no `rd_data` arrives in that cycle, `oerr` is set and the new byte replaces the old one.
- R10: A `rd_status` pulse clears `brk`, `ferr`, `perr` and `oerr`. If a character completes in the same cycle, the flags it raises are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code |
| cfg_par | input | 3 | Parity mode code |
| rd_data | input | 1 | Host takes the buffered byte |
| rd_status | input | 1 | Host reads the error flags |
| req_ack | input | 1 | Host acknowledges the request flag |
| rx_byte | output | 8 | Buffered character |
| rx_full | output | 1 | Buffer holds an unread byte |
| rx_req | output | 1 | Character-stored request |
| brk | output | 1 | Break detected |
| ferr | output | 1 | Framing error |
| perr | output | 1 | Parity error |
| oerr | output | 1 | Overrun error |

## Verification
The receiver is driven with bit patterns of alternating and asymmetric polarity at all four lengths. A wrong bit order, a wrong sampling phase or missing zero fill each shows up as a distinct wrong byte. Every parity mode is exercised with a correct parity bit and with a wrong one, which separates the odd, even and forced checks from one another. An all-zero frame with a low stop bit is contrasted with a low stop bit after nonzero data and with all-zero data followed by a good stop bit, so that break and framing are told apart. A short low pulse and back-to-back unread characters cover start validation and overrun.

// File: rtl/serial_rx_16x.sv
module serial_rx_16x #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic       rd_data,
  input  logic       rd_status,
  input  logic       req_ack,
  output logic [7:0] rx_byte,
  output logic       rx_full,
  output logic       rx_req,
  output logic       brk,
  output logic       ferr,
  output logic       perr,
  output logic       oerr
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST_T = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF_T = CW'(OSR / 2 - 1);

  typedef enum logic [2:0] {HUNT, START, DATA, PARB, STOP} st_t;

  st_t           st_q;
  logic [CW-1:0] tcnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    shf_q;
  logic          par_q;

  logic       par_en, at_mid, done, par_bad, all_low, ovr;
  logic [2:0] last_bit;

  assign par_en   = cfg_par[0];
  assign last_bit = 3'd4 + {1'b0, cfg_len};
  assign at_mid   = tick && (tcnt_q == LAST_T);
  assign done     = at_mid && (st_q == STOP);
  assign par_bad  = par_en && (cfg_par[2] ? (par_q == cfg_par[1])
                                          : ((^shf_q ^ par_q) == cfg_par[1]));
  assign all_low  = (shf_q == 8'h00) && !(par_en && par_q) && !rxd;
  assign ovr      = rx_full && !rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HUNT;
      tcnt_q <= '0;
      bit_q  <= '0;
      shf_q  <= '0;
      par_q  <= 1'b0;
    end else if (tick) begin
      case (st_q)
        HUNT: if (!rxd) begin
          st_q   <= START;
          tcnt_q <= '0;
        end
        START: if (tcnt_q == HALF_T) begin
          tcnt_q <= '0;
          if (rxd) st_q <= HUNT;
          else begin
            st_q  <= DATA;
            bit_q <= '0;
            shf_q <= '0;
          end
        end else tcnt_q <= tcnt_q + 1'b1;
        DATA: if (at_mid) begin
          shf_q[bit_q] <= rxd;
          bit_q        <= bit_q + 1'b1;
          tcnt_q       <= '0;
          if (bit_q == last_bit) st_q <= par_en ? PARB : STOP;
        end else tcnt_q <= tcnt_q + 1'b1;
        PARB: if (at_mid) begin
          par_q  <= rxd;
          tcnt_q <= '0;
          st_q   <= STOP;
        end else tcnt_q <= tcnt_q + 1'b1;
        STOP: if (at_mid) begin
          tcnt_q <= '0;
          st_q   <= HUNT;
        end else tcnt_q <= tcnt_q + 1'b1;
        default: st_q <= HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      rx_full <= 1'b0;
      rx_req  <= 1'b0;
      brk     <= 1'b0;
      ferr    <= 1'b0;
      perr    <= 1'b0;
      oerr    <= 1'b0;
    end else begin
      if (done) rx_byte <= shf_q;
      rx_full <= done | (rx_full & ~rd_data);
      rx_req  <= done | (rx_req & ~rd_data & ~req_ack);
      brk     <= (done & all_low) | (brk  & ~rd_status);
      ferr    <= (done & ~rxd)    | (ferr & ~rd_status);
      perr    <= (done & par_bad) | (perr & ~rd_status);
      oerr    <= (done & ovr)     | (oerr & ~rd_status);
    end
  end
endmodule

module serial_rx_16x_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       rd_data,
  input logic       rd_status,
  input logic [1:0] cfg_len,
  input logic [7:0] rx_byte,
  input logic       rx_full,
  input logic       rx_req,
  input logic       brk,
  input logic       ferr,
  input logic       perr,
  input logic       oerr
);
  a_r8_store_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> rx_req);
  a_r8_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> (!rx_full && !rx_req));
  a_r10_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !done) |=> !(brk || ferr || perr || oerr));
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full && !rd_data) |=> oerr);
  a_r7_break_framing: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> ferr);
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_len == 2'b00) |=> (rx_byte[7:5] == 3'b000));
endmodule

bind serial_rx_16x serial_rx_16x_chk chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .rd_data(rd_data),
  .rd_status(rd_status), .cfg_len(cfg_len), .rx_byte(rx_byte),
  .rx_full(rx_full), .rx_req(rx_req), .brk(brk), .ferr(ferr),
  .perr(perr), .oerr(oerr)
);

// File: tb/serial_rx_16x_tb.sv
module serial_rx_16x_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic [2:0] cfg_par = 3'b000;
  logic       rd_data = 1'b0, rd_status = 1'b0, req_ack = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_full, rx_req, brk, ferr, perr, oerr;
  int n_chk = 0, n_bad = 0;

  serial_rx_16x dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .rd_data(rd_data), .rd_status(rd_status),
    .req_ack(req_ack), .rx_byte(rx_byte), .rx_full(rx_full), .rx_req(rx_req),
    .brk(brk), .ferr(ferr), .perr(perr), .oerr(oerr)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wtick(int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  task automatic drive(logic v);
    #1 rxd = v;
    wtick(16);
  endtask

  task automatic send(logic [7:0] d, int nb, bit pe, bit pb, bit sb);
    wtick(1);
    drive(1'b0);
    for (int i = 0; i < nb; i++) drive(d[i]);
    if (pe) drive(pb);
    drive(sb);
    #1 rxd = 1'b1;
    wtick(24);
    @(negedge clk);
  endtask

  task automatic pulse(int sel);
    @(negedge clk);
    if (sel == 0) rd_data = 1'b1;
    else if (sel == 1) rd_status = 1'b1;
    else req_ack = 1'b1;
    @(negedge clk);
    rd_data = 1'b0; rd_status = 1'b0; req_ack = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit pbit(logic [7:0] d, int nb, logic [2:0] m);
    logic x = ^(d & 8'((1 << nb) - 1));
    case (m)
      3'b001: return ~x;
      3'b011: return x;
      3'b101: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] flags();
    return {brk, ferr, perr, oerr};
  endfunction

  task automatic t_reset;
    chk("R1 full", rx_full, 0);
    chk("R1 req", rx_req, 0);
    chk("R1 flags", flags(), 0);
  endtask

  task automatic t_data8;
    cfg_len = 2'b11; cfg_par = 3'b000;
    send(8'hA5, 8, 0, 0, 1);
    chk("R3 byte A5", rx_byte, 8'hA5);
    chk("R8 full set", rx_full, 1);
    chk("R8 req set", rx_req, 1);
    chk("R6 no error", flags(), 0);
    send(8'h96, 8, 0, 0, 1);
    chk("R9 replaced 96", rx_byte, 8'h96);
    chk("R9 overrun", oerr, 1);
    pulse(1);
    chk("R10 cleared", flags(), 0);
    pulse(0);
    chk("R8 read full", rx_full, 0);
    chk("R8 read req", rx_req, 0);
  endtask

  task automatic t_len;
    cfg_len = 2'b00;
    send(8'hF3, 5, 0, 0, 1);
    chk("R4 len5", rx_byte, 8'h13);
    pulse(0);
    cfg_len = 2'b01;
    send(8'hFF, 6, 0, 0, 1);
    chk("R4 len6", rx_byte, 8'h3F);
    pulse(0);
    cfg_len = 2'b10;
    send(8'hD5, 7, 0, 0, 1);
    chk("R4 len7", rx_byte, 8'h55);
    pulse(0);
    cfg_len = 2'b11;
  endtask

  task automatic t_parity;
    logic [2:0] modes [4] = '{3'b001, 3'b011, 3'b101, 3'b111};
    for (int k = 0; k < 4; k++) begin
      cfg_par = modes[k];
      send(8'h37, 8, 1, pbit(8'h37, 8, modes[k]), 1);
      chk("R5 good parity", perr, 0);
      chk("R5 good byte", rx_byte, 8'h37);
      pulse(0);
      send(8'h37, 8, 1, ~pbit(8'h37, 8, modes[k]), 1);
      chk("R5 bad parity", perr, 1);
      pulse(0);
      pulse(1);
      chk("R10 perr clear", perr, 0);
    end
    cfg_par = 3'b000;
  endtask

  task automatic t_frame_break;
    send(8'h5A, 8, 0, 0, 0);
    chk("R6 ferr", ferr, 1);
    chk("R7 no brk", brk, 0);
    pulse(0); pulse(1);
    chk("R10 ferr clear", ferr, 0);
    send(8'h00, 8, 0, 0, 1);
    chk("R7 zero data good stop", {brk, ferr}, 2'b00);
    pulse(0);
    send(8'h00, 8, 0, 0, 0);
    chk("R7 break", {brk, ferr}, 2'b11);
    pulse(0); pulse(1);
    cfg_par = 3'b011;
    send(8'h00, 8, 1, 0, 0);
    chk("R7 break w/ parity", {brk, ferr, perr}, 3'b110);
    pulse(0); pulse(1);
    chk("R10 all clear", flags(), 0);
    cfg_par = 3'b000;
  endtask

  task automatic t_ack;
    send(8'hC3, 8, 0, 0, 1);
    pulse(2);
    chk("R8 ack req", rx_req, 0);
    chk("R8 ack keeps full", rx_full, 1);
    chk("R8 ack keeps byte", rx_byte, 8'hC3);
    pulse(0);
  endtask

  task automatic t_glitch;
    wtick(1);
    #1 rxd = 1'b0;
    wtick(4);
    #1 rxd = 1'b1;
    wtick(40);
    @(negedge clk);
    chk("R2 glitch no char", rx_full, 0);
    send(8'h81, 8, 0, 0, 1);
    chk("R2 after glitch", rx_byte, 8'h81);
    pulse(0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_data8;
    t_len;
    t_parity;
    t_frame_break;
    t_ack;
    t_glitch;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule